// File: doc/BRIEF.md
# Carry-Skip Adder

This block adds two unsigned N-bit operands and a carry input in purely combinational logic. The operand width is cut into M equal groups of P bit cells. Every cell first forms a propagate term (the two operand bits differ) and a generate term (both operand bits are one). Inside a group the carry ripples from cell to cell.

Each group also reduces its propagate terms to one group-propagate flag. When that flag is set, every cell in the group would pass its incoming carry through unchanged. A bypass multiplexer therefore hands the group's carry input straight to the next group and does not wait for the ripple chain. The slowest path is a carry generated in the lowest group. It then jumps over each middle group and ripples through the top group. The group-propagate flags are brought out on a port so that a bench or a neighbouring block can observe them.

The configuration is fixed at elaboration. N must be a whole multiple of P, and a bad pair stops elaboration. A parameter selects how each group reduces its propagate terms: either a balanced reduction or a linear chain.

Top module: `carry_skip_adder`

## Requirements
- R1: `sum_o` equals the low N bits of `a_i + b_i + c_i`, with all three values taken as unsigned.
- R2: `c_o` equals bit N of the unsigned (N+1)-bit result of `a_i + b_i + c_i`.
- R3: `grp_prop_o[j]` is 1 exactly when every bit position in group j has `a_i` and `b_i` at different values. Group j covers operand bits j*P up to j*P+P-1, and group 0 holds the least significant bits.
- R4: When the two operands differ in every bit, `sum_o` is all ones with `c_i`=0 and all zeros with `c_i`=1, `c_o` equals `c_i`, and every bit of `grp_prop_o` is 1.
- R5: A group whose flag is set passes its incoming carry on unchanged. A carry produced in the bits below such a group therefore still reaches the sum bits above it.
- R6: The worst case gives exact results. In that case a carry is generated in bit 0 and travels through every higher bit, for example `a_i` all ones with `b_i`=1, or `a_i` all ones with `b_i`=0 and `c_i`=1. Both give `sum_o`=0 and `c_o`=1.
- R7: The outputs depend only on the present inputs. A new operand pair gives settled results within the same cycle, and earlier operands leave nothing behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum, low N bits |
| c_o | output | 1 | Carry out of bit N-1 |
| grp_prop_o | output | N/P | Group-propagate flag per group, group 0 in bit 0 |

## Verification
The carry between two groups is internal, so a wrong bypass decision shows only at the ports. A bypass taken when a group does not propagate, or a bypass that drops a carry, changes the sum bits of the next group up or flips `c_o`. The error appears in the same evaluation as the operands that trigger it. The bench therefore drives, for each group in turn, operands that make only that group propagate while a carry enters it from below, and it adds the end-to-end worst case. A faulty group-propagate reduction is also caught directly, because the bench compares `grp_prop_o` with flags it computes from the operands.

// File: rtl/csa_pkg.sv
package csa_pkg;

   // Number of equal groups for a given width and group size.
   function automatic int csa_groups(input int width, input int grp);
      return (grp > 0) ? (width / grp) : 0;
   endfunction

   // Propagate-reduction variants selectable per instance.
   typedef enum int {
      GP_REDUCE_TREE  = 0,
      GP_REDUCE_CHAIN = 1
   } gp_style_e;

endpackage

// File: rtl/csa_pg_cell.sv
module csa_pg_cell (
   input  logic a_i,
   input  logic b_i,
   output logic p_o,
   output logic g_o
);

   assign p_o = a_i ^ b_i;
   assign g_o = a_i & b_i;

endmodule

// File: rtl/csa_ripple_chain.sv
module csa_ripple_chain #(
   parameter int W = 4
) (
   input  logic [W-1:0] p_i,
   input  logic [W-1:0] g_i,
   input  logic         c_i,
   output logic [W-1:0] s_o,
   output logic         c_o
);

   initial begin
      if (W < 1) $error("csa_ripple_chain: W must be at least 1");
   end

   always_comb begin
      logic c;
      c = c_i;
      for (int k = 0; k < W; k++) begin
         s_o[k] = p_i[k] ^ c;
         c      = g_i[k] | (p_i[k] & c);
      end
      c_o = c;
   end

endmodule

// File: rtl/csa_prop_reduce.sv
module csa_prop_reduce #(
   parameter int W     = 4,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] p_i,
   output logic         all_o
);
   import csa_pkg::*;

   generate
      if (STYLE == GP_REDUCE_CHAIN) begin : g_chain
         logic [W:0] acc;
         assign acc[0] = 1'b1;
         for (genvar k = 0; k < W; k++) begin : g_link
            assign acc[k+1] = acc[k] & p_i[k];
         end
         assign all_o = acc[W];
      end else begin : g_tree
         assign all_o = &p_i;
      end
   endgenerate

endmodule

// File: rtl/csa_skip_group.sv
module csa_skip_group #(
   parameter int P     = 4,
   parameter int STYLE = 0
) (
   input  logic [P-1:0] a_i,
   input  logic [P-1:0] b_i,
   input  logic         c_i,
   output logic [P-1:0] s_o,
   output logic         c_o,
   output logic         gp_o
);

   logic [P-1:0] p_bit;
   logic [P-1:0] g_bit;
   logic         ripple_c;

   for (genvar k = 0; k < P; k++) begin : g_cell
      csa_pg_cell u_pg (
         .a_i (a_i[k]),
         .b_i (b_i[k]),
         .p_o (p_bit[k]),
         .g_o (g_bit[k])
      );
   end

   csa_ripple_chain #(.W(P)) u_chain (
      .p_i (p_bit),
      .g_i (g_bit),
      .c_i (c_i),
      .s_o (s_o),
      .c_o (ripple_c)
   );

   csa_prop_reduce #(.W(P), .STYLE(STYLE)) u_gp (
      .p_i   (p_bit),
      .all_o (gp_o)
   );

   // Bypass multiplexer: a fully propagating group forwards its carry in.
   assign c_o = gp_o ? c_i : ripple_c;

   // Group-level checks on settled, known values.
   always_comb begin
      if (!$isunknown({a_i, b_i, c_i})) begin
         a_r5_bypass_agrees_ripple: assert (!gp_o || (ripple_c == c_i))
            else $error("R5: bypass taken while ripple carry %0b != carry in %0b", ripple_c, c_i);
         a_r1_group_sum: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{P{1'b0}}, c_i}))
            else $error("R1: group result %0h wrong", {c_o, s_o});
      end
   end

endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
   parameter int N        = 24,
   parameter int P        = 4,
   parameter int GP_STYLE = 0,
   localparam int M       = csa_pkg::csa_groups(N, P)
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         c_i,
   output logic [N-1:0] sum_o,
   output logic         c_o,
   output logic [M-1:0] grp_prop_o
);

   generate
      if (P < 1 || N < P || (N % P) != 0) begin : g_bad_cfg
         $error("carry_skip_adder: P must be at least 1 and divide N exactly");
      end
   endgenerate

   logic [M:0] grp_c;
   assign grp_c[0] = c_i;

   for (genvar j = 0; j < M; j++) begin : g_grp
      csa_skip_group #(.P(P), .STYLE(GP_STYLE)) u_grp (
         .a_i  (a_i[j*P +: P]),
         .b_i  (b_i[j*P +: P]),
         .c_i  (grp_c[j]),
         .s_o  (sum_o[j*P +: P]),
         .c_o  (grp_c[j+1]),
         .gp_o (grp_prop_o[j])
      );
   end

   assign c_o = grp_c[M];

   always_comb begin
      if (!$isunknown({a_i, b_i, c_i})) begin
         a_r2_carry_out: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c_i}))
            else $error("R2: result %0h wrong", {c_o, sum_o});
         a_r4_full_propagate: assert (!(&grp_prop_o) || (c_o == c_i))
            else $error("R4: all groups propagate but carry out %0b != carry in %0b", c_o, c_i);
      end
   end

endmodule

// File: tb/tb_carry_skip_adder.sv
module tb_carry_skip_adder;
   localparam int N = 24;
   localparam int P = 4;
   localparam int M = N / P;
   localparam logic [N-1:0] ONES = {N{1'b1}};

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [N-1:0] a, b, sum;
   logic         cin, cout;
   logic [M-1:0] gp;

   int checks = 0;
   int errors = 0;

   carry_skip_adder #(.N(N), .P(P)) dut (
      .a_i (a), .b_i (b), .c_i (cin),
      .sum_o (sum), .c_o (cout), .grp_prop_o (gp)
   );

   function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
   endfunction

   function automatic logic [M-1:0] ref_gp(input logic [N-1:0] x, input logic [N-1:0] y);
      logic [M-1:0] r;
      for (int j = 0; j < M; j++) begin
         r[j] = 1'b1;
         for (int k = 0; k < P; k++) if (x[j*P+k] == y[j*P+k]) r[j] = 1'b0;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply_and_check(input logic [N-1:0] x, input logic [N-1:0] y, input logic c, input string tag);
      logic [N:0] r;
      @(posedge clk);
      a = x; b = y; cin = c;
      @(negedge clk);
      r = ref_add(x, y, c);
      check({tag, " R1 sum"}, 32'(sum), 32'(r[N-1:0]));
      check({tag, " R2 cout"}, 32'(cout), 32'(r[N]));
      check({tag, " R3 group flags"}, 32'(gp), 32'(ref_gp(x, y)));
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] x, y;
      a = '0; b = '0; cin = 1'b0;
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      // Idle state: zero operands
      check("R1 zero sum", 32'(sum), 32'h0);
      check("R2 zero cout", 32'(cout), 32'h0);
      check("R3 zero flags", 32'(gp), 32'h0);

      // R4: operands differ everywhere
      apply_and_check(ONES, '0, 1'b0, "R4 ones+0 c0");
      check("R4 sum all ones", 32'(sum), 32'(ONES));
      apply_and_check(ONES, '0, 1'b1, "R4 ones+0 c1");
      check("R4 sum zero", 32'(sum), 32'h0);
      check("R4 cout follows cin", 32'(cout), 32'h1);
      apply_and_check(24'hAAAAAA, 24'h555555, 1'b1, "R4 alternating");
      check("R4 all flags", 32'(gp), 32'(ONES[M-1:0]));

      // R6: worst case carry generated at bit 0
      apply_and_check(ONES, 24'h000001, 1'b0, "R6 gen bit0");
      check("R6 sum zero", 32'(sum), 32'h0);
      check("R6 cout one", 32'(cout), 32'h1);
      check("R6 flags", 32'(gp), 32'(ONES[M-1:0] & ~1));
      apply_and_check(ONES, '0, 1'b1, "R6 cin through all");

      // R5: one propagating group, carry generated just below it
      for (int j = 1; j < M; j++) begin
         x = '0; y = '0;
         x[j*P +: P] = '1;
         x[j*P-1] = 1'b1;
         y[j*P-1] = 1'b1;
         apply_and_check(x, y, 1'b0, "R5 skip group");
         check("R5 flag of skipped group", 32'(gp[j]), 32'h1);
      end

      // R7: consecutive random vectors, no memory of earlier ones
      for (int i = 0; i < 400; i++) begin
         x = N'($urandom);
         y = N'($urandom);
         if (i % 4 == 0) y = ~x ^ N'(1 << ($urandom % N));
         apply_and_check(x, y, 1'($urandom), "R7 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule